// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Input Pullups

This block is one 8-bit general-purpose I/O port hanging off a simple single-cycle peripheral register bus. Software sees three byte registers: a data latch, a direction register and a pullup-enable register. Each pin is driven to the pad ring as an output-enable, an output value and a pullup request. Pin levels come back through a two-flop synchronizer.

A read of the data register is assembled bit by bit. Pins set as outputs return the latch contents, and pins set as inputs return the synchronized pad level. A pullup request reaches the pad only while its pin is an input, and the stored enable bit is left alone when the direction changes. The analog pad, alternate-function pin sharing and interrupts are handled outside this block.

Top module: `gpio_byte_port`

## Requirements
- R1: After a synchronous active-low reset, the data latch, the direction register and the pullup-enable register all hold 0x00, so pad_oe = 0x00, pad_out = 0x00 and pad_pu = 0x00.
- R2: A write to the data register (offset 0x3) updates the latch on the next clock edge, whatever the direction bits are, and pad_out always equals the latch.
- R3: A write to the direction register (offset 0x7) takes effect on the next clock edge, and pad_oe bit i equals direction bit i (1 = output, 0 = input).
- R4: A read of offset 0x3 returns, for each bit i, the latch bit when direction bit i is 1 and the synchronized pin bit when direction bit i is 0.
- R5: A pin level sampled at clock edge k shows up in data-register read data from edge k+2 onward, which means two synchronizer flops.
- R6: pad_pu bit i is 1 only when pullup-enable bit i (offset 0xF) is 1 and direction bit i is 0. Changing the direction never alters the stored pullup-enable value that is read back.
- R7: The direction register and the pullup-enable register each read back the last value written to them, at offsets 0x7 and 0xF.
- R8: A read of any offset other than 0x3, 0x7 or 0xF returns 0x00, and bus_rdata is 0x00 whenever bus_rd is low. A write to such an offset changes no register.
- R9: An input pin with its pullup disabled is high impedance: both pad_oe and pad_pu are 0 for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, captured at the clock edge |
| bus_rd | input | 1 | Read strobe, gates bus_rdata in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr and register state |
| pin_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pullup enable |

## Verification
On every cycle the embedded assertions check four things: a pullup is never requested on a pin that is driving, a write to the latch or the direction register shows up on the next edge, the first synchronizer stage follows the pin one cycle late, and writes to unmapped offsets leave every register unchanged. The per-bit composition of data read data and the two-cycle pin-to-read latency involve the bench's own model of pin history. The same holds for the readback of registers and for zero data on unmapped reads. These behaviours are therefore shown by the bench scenarios, which compare each cycle against a behavioural model under directed and random traffic.

// File: rtl/gpio_port_pkg.sv
// Package: shared register-select type for the GPIO port.
// Assumes: exactly three mapped registers; everything else decodes to NONE.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PUE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
// Module: gpio_addr_dec
// Maps a bus byte offset to one of the port registers.
// Assumes: the offsets are distinct and fit in ADDR_W bits.
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_OFS = 3,
    parameter int unsigned DIR_OFS  = 7,
    parameter int unsigned PUE_OFS  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] PueA  = ADDR_W'(PUE_OFS);

    // Purpose: compare the offset against each mapped register.
    always_comb begin
        if (addr == DataA)     sel = SEL_DATA;
        else if (addr == DirA) sel = SEL_DIR;
        else if (addr == PueA) sel = SEL_PUE;
        else                   sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: gpio_ctrl_regs
// Holds the data latch, the direction register and the pullup-enable register.
// Assumes: writes take effect at the clock edge; synchronous active-low reset.
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dat_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pue_q
);
    // Purpose: data latch, written regardless of direction.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dat_q <= '0;
        else if (wr && sel == SEL_DATA)    dat_q <= wdata;
    end

    // Purpose: direction register, all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_q <= '0;
        else if (wr && sel == SEL_DIR)     dir_q <= wdata;
    end

    // Purpose: pullup-enable register, all pullups off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pue_q <= '0;
        else if (wr && sel == SEL_PUE)     pue_q <= wdata;
    end

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA) |=> (dat_q == $past(wdata)));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_NONE) |=> ($stable(dat_q) && $stable(dir_q) && $stable(pue_q)));
endmodule

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Brings asynchronous pin levels into the clock domain through a flop chain.
// Assumes: STAGES >= 2; the flops are not reset, so they settle within STAGES clocks.
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    // Purpose: first stage samples the raw pins.
    always_ff @(posedge clk) begin
        stg[0] <= pin_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Purpose: each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign pin_sync = stg[STAGES-1];

    // R5
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg[0] == $past(pin_in));
endmodule

// File: rtl/gpio_read_path.sv
// Module: gpio_read_path
// Builds bus read data and gates the pullup requests by direction.
// Assumes: read data is combinational; unmapped or idle reads give zero.
module gpio_read_path
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  reg_sel_e         sel,
    input  logic             rd,
    input  logic [WIDTH-1:0] dat_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pue_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] pad_pu
);
    logic [WIDTH-1:0] data_view;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Purpose: per-bit source pick, latch for outputs and pin for inputs.
        assign data_view[b] = dir_q[b] ? dat_q[b] : pin_sync[b];
        // Purpose: pullup only on an input with its enable set.
        assign pad_pu[b]    = pue_q[b] & ~dir_q[b];
    end

    // Purpose: select register contents for the bus.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_DATA: rdata = data_view;
                SEL_DIR:  rdata = dir_q;
                SEL_PUE:  rdata = pue_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_byte_port.sv
// Module: gpio_byte_port
// Bus-mapped GPIO port: data latch, direction and pullup-enable registers,
// pad control outputs and synchronized pin readback.
// Assumes: single-cycle bus; synchronous active-low reset.
module gpio_byte_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned SYNC_STG = 2,
    parameter int unsigned DATA_OFS = 3,
    parameter int unsigned DIR_OFS  = 7,
    parameter int unsigned PUE_OFS  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] dat_q, dir_q, pue_q, pin_sync;

    gpio_addr_dec #(
        .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PUE_OFS(PUE_OFS)
    ) dec_i (
        .addr(bus_addr), .sel(sel)
    );

    gpio_ctrl_regs #(.WIDTH(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
        .dat_q(dat_q), .dir_q(dir_q), .pue_q(pue_q)
    );

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    gpio_read_path #(.WIDTH(WIDTH)) rdp_i (
        .sel(sel), .rd(bus_rd), .dat_q(dat_q), .dir_q(dir_q), .pue_q(pue_q),
        .pin_sync(pin_sync), .rdata(bus_rdata), .pad_pu(pad_pu)
    );

    // Purpose: pad drive follows direction and latch directly.
    assign pad_oe  = dir_q;
    assign pad_out = dat_q;

    // R6
    pu_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(DIR_OFS)) |=> (pad_oe == $past(bus_wdata)));
endmodule

// File: tb/gpio_byte_port_tb_top.sv
`timescale 1ns/1ps
module gpio_byte_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, pin_in = '0;
    logic [7:0] bus_rdata, pad_oe, pad_out, pad_pu;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_dat = '0, m_dir = '0, m_pue = '0;
    logic [7:0] pin_hist [$];

    always #2.5 clk = ~clk;

    gpio_byte_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(logic [3:0] a, logic rd);
        logic [7:0] synced;
        synced = pin_hist[0];
        if (!rd) return 8'h00;
        case (a)
            4'h3: return (m_dat & m_dir) | (synced & ~m_dir);
            4'h7: return m_dir;
            4'hF: return m_pue;
            default: return 8'h00;
        endcase
    endfunction

    // One bus cycle: drive at negedge, compare, then advance model at posedge.
    task automatic cyc(logic [3:0] a, logic w, logic r, logic [7:0] d, logic [7:0] p);
        string rq;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; pin_in = p;
        #1;
        if (rst_n) begin
            rq = (!r || !(a == 4'h3 || a == 4'h7 || a == 4'hF)) ? "R8" :
                 (a == 4'h3) ? "R4/R5" : "R7";
            check(rq, bus_rdata, exp_rdata(a, r));
            check("R3", pad_oe, m_dir);
            check("R2", pad_out, m_dat);
            check("R6", pad_pu, m_pue & ~m_dir);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_dat = '0; m_dir = '0; m_pue = '0;
        end else if (w) begin
            case (a)
                4'h3: m_dat = d;
                4'h7: m_dir = d;
                4'hF: m_pue = d;
                default: ;
            endcase
        end
        // two-stage pin history: front entry is what read data shows
        pin_hist.push_back(p);
        while (pin_hist.size() > 2) void'(pin_hist.pop_front());
    endtask

    initial begin
        pin_hist.push_back(8'h00);
        pin_hist.push_back(8'h00);
        repeat (4) cyc(4'h0, 0, 0, 8'h00, 8'h00);
        rst_n = 1'b1;
        // R1: reset state at the ports and in readback
        @(negedge clk); #1;
        check("R1", pad_oe, 8'h00);
        check("R1", pad_out, 8'h00);
        check("R1", pad_pu, 8'h00);
        cyc(4'h7, 0, 1, 8'h00, 8'h00);
        cyc(4'hF, 0, 1, 8'h00, 8'h00);
        // R9: input, pullup off -> oe and pu low
        @(negedge clk); #1;
        check("R9", pad_oe | pad_pu, 8'h00);
        // R2: latch written while all pins are inputs
        cyc(4'h3, 1, 0, 8'hA5, 8'h3C);
        cyc(4'h3, 0, 1, 8'h00, 8'h3C);
        cyc(4'h3, 0, 1, 8'h00, 8'h3C);
        // R3/R4: upper nibble output
        cyc(4'h7, 1, 0, 8'hF0, 8'h3C);
        cyc(4'h3, 0, 1, 8'h00, 8'h3C);
        // R6: pullups on everywhere, masked on outputs, stored value intact
        cyc(4'hF, 1, 0, 8'hFF, 8'h3C);
        cyc(4'hF, 0, 1, 8'h00, 8'h3C);
        cyc(4'h7, 1, 0, 8'h00, 8'h3C);
        cyc(4'hF, 0, 1, 8'h00, 8'h3C);
        cyc(4'h7, 1, 0, 8'hFF, 8'h3C);
        cyc(4'hF, 0, 1, 8'h00, 8'h3C);
        // R8: unmapped writes and reads, idle read strobe
        cyc(4'h5, 1, 0, 8'h77, 8'h3C);
        cyc(4'h5, 0, 1, 8'h00, 8'h3C);
        cyc(4'h3, 0, 0, 8'h00, 8'h3C);
        // R5: pin toggles seen two edges later on input bits
        cyc(4'h7, 1, 0, 8'h00, 8'h3C);
        for (int i = 0; i < 8; i++) cyc(4'h3, 0, 1, 8'h00, 8'(1 << i));
        cyc(4'h3, 0, 1, 8'h00, 8'hFF);
        cyc(4'h3, 0, 1, 8'h00, 8'h00);
        cyc(4'h3, 0, 1, 8'h00, 8'h00);
        // random traffic against the model (all requirements)
        for (int i = 0; i < 2000; i++)
            cyc(4'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
        // R1: reset in mid-run clears everything again
        rst_n = 1'b0;
        cyc(4'h0, 0, 0, 8'h00, 8'h00);
        cyc(4'h0, 0, 0, 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", pad_oe | pad_out | pad_pu, 8'h00);
        cyc(4'hF, 0, 1, 8'h00, 8'h00);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule